// File: doc/BRIEF.md
# Grouped Interrupt Steering Aggregator

This block gathers a parameterised number of level-sensitive interrupt lines (a multiple of 32) and reduces them to a few output lines, one for every 64 inputs. Software reaches the block through a simple word-wide register bus, with a write strobe, a byte address, write data and read data that follows the address combinationally. Through this bus it enables individual inputs, forces inputs pending for test or software-raised events, and reads back which enabled inputs are pending.

Each register bank holds one 32-bit word per group of 32 inputs. The banks are laid out highest-group-first: the word at the lowest address of a bank covers the top 32 inputs. Steering to the outputs happens only when the channel control word has the configured channel's bit set. A master-disable word then silences every output while leaving the pending state visible. Status and outputs are registered, so they follow an input change by one clock.

Top module: `irq_group_steer`

## Requirements
- R1: After reset the channel control, every enable word, every force word and the master-disable word read zero, every status bit reads zero, and all outputs are low.
- R2: The channel control word sits at byte offset 0x0 and reads back as written. Outputs can be driven only while its bit CHAN_ID is 1. Any other bit pattern leaves all outputs low.
- R3: With NW = NUM_IN/32, the enable bank starts at offset 0x4. Input k is enabled by bit (k mod 32) of the word at 0x4 + 4*(NW-1-k/32), so the lowest address holds the highest inputs. A 1 enables the input. Every word reads back as written.
- R4: The force bank starts at 4*NW+0x4 and uses the same reversed word order. A 1 makes the input pending, ORed with its hardware line, until it is written back to 0. The words read back as written.
- R5: The status bank starts at 8*NW+0x4 and uses the reversed word order. Each bit equals (line OR force) AND enable, as sampled on the previous clock edge. Writes to this bank have no effect.
- R6: Output j (there are ceil(NUM_IN/64) of them) is 1 one clock after any enabled pending input in 64*j..64*j+63 is seen, provided the channel bit is set and master-disable is zero.
- R7: The master-disable word sits at 12*NW+0x4 and reads back as written. While it is nonzero all outputs are 0. The master-status word at 12*NW+0x8 holds, in bit j, the ungated group OR behind output j, and it stays readable while the outputs are gated.
- R8: Writes to unmapped or misaligned (address bits [1:0] not zero) offsets change nothing. Reads of them return zero.
- R9: Inputs are levels. An output falls one clock after the last enabled pending input of its group drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IN | Level-sensitive interrupt inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq_out | output | NOUT | One output per 64-input group |

## Verification
The bench targets the reversed word order. An input 0 enabled through the lowest enable word instead of the highest would light the wrong output, or no output at all. It checks that a channel word with a neighbouring bit set leaves the outputs quiet, and that writing the read-only status bank does not corrupt the enable or force state; a design that decoded these wrongly would assert interrupts while software believed them off. It also drives master-disable: a design that gated the master-status word together with the outputs would hide the pending groups. Finally it covers misaligned and out-of-range addresses, where a partial decode would alias onto real registers.

// File: rtl/irq_group_steer.sv
module irq_group_steer #(
  parameter int NUM_IN  = 128,
  parameter int CHAN_ID = 0,
  parameter int ADDR_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_IN-1:0]             irq_in,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [31:0]                   wdata,
  output logic [31:0]                   rdata,
  output logic [(NUM_IN+63)/64-1:0]     irq_out
);
  localparam int NW   = NUM_IN / 32;
  localparam int NOUT = (NUM_IN + 63) / 64;
  localparam int W_MDIS = 3*NW + 1;
  localparam int W_MSTAT = 3*NW + 2;

  logic [31:0]       ctrl_q, mdis_q;
  logic [NUM_IN-1:0] mask_q, force_q, stat_q, pend;
  logic [NOUT-1:0]   grp_d, grp_q;
  logic              aligned, mapped, gate;
  int                wi;

  assign aligned = (addr[1:0] == 2'b00);
  assign wi      = int'(addr[ADDR_W-1:2]);
  assign mapped  = aligned && (wi <= W_MSTAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      mdis_q  <= '0;
      mask_q  <= '0;
      force_q <= '0;
    end else if (wr_en && aligned) begin
      if (wi == 0) ctrl_q <= wdata;
      if (wi == W_MDIS) mdis_q <= wdata;
      for (int i = 0; i < NW; i++) begin
        if (wi == 1 + i)      mask_q[32*(NW-1-i) +: 32]  <= wdata;
        if (wi == 1 + NW + i) force_q[32*(NW-1-i) +: 32] <= wdata;
      end
    end
  end

  assign pend = (irq_in | force_q) & mask_q;

  for (genvar j = 0; j < NOUT; j++) begin : g_grp
    localparam int GW = (NUM_IN - 64*j >= 64) ? 64 : NUM_IN - 64*j;
    assign grp_d[j] = |pend[64*j +: GW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      grp_q  <= '0;
    end else begin
      stat_q <= pend;
      grp_q  <= grp_d;
    end
  end

  assign gate    = ctrl_q[CHAN_ID] && (mdis_q == '0);
  assign irq_out = grp_q & {NOUT{gate}};

  always_comb begin
    rdata = '0;
    if (aligned) begin
      if (wi == 0)       rdata = ctrl_q;
      if (wi == W_MDIS)  rdata = mdis_q;
      if (wi == W_MSTAT) rdata[NOUT-1:0] = grp_q;
      for (int i = 0; i < NW; i++) begin
        if (wi == 1 + i)        rdata = mask_q[32*(NW-1-i) +: 32];
        if (wi == 1 + NW + i)   rdata = force_q[32*(NW-1-i) +: 32];
        if (wi == 1 + 2*NW + i) rdata = stat_q[32*(NW-1-i) +: 32];
      end
    end
  end

  // R3
  mask_word_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(4)) |=> (mask_q[NUM_IN-1 -: 32] == $past(wdata)));

  // R5
  status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8*NW + 4)) |=> ($stable(mask_q) && $stable(force_q)));

  // R7
  mdis_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(12*NW + 4) && wdata != '0) |=> (irq_out == '0));

  // R6
  out_within_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_out) |-> ((irq_out & ~grp_q) == '0));

  // R8
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mapped) |=> ($stable(ctrl_q) && $stable(mdis_q) && $stable(mask_q) && $stable(force_q)));

  // R9
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in == '0 && force_q == '0) |=> (irq_out == '0));
endmodule

// File: tb/sim_irq_group_steer.sv
module sim_irq_group_steer;
  localparam int NUM_IN = 128;
  localparam int NW = NUM_IN / 32;
  localparam int NOUT = (NUM_IN + 63) / 64;
  localparam int CHAN = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_IN-1:0] irq_in = '0;
  logic wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NOUT-1:0] irq_out;

  int nchk = 0, nerr = 0;

  logic [NUM_IN-1:0] m_mask, m_force, m_stat;
  logic [31:0] m_ctrl, m_mdis;
  logic [NOUT-1:0] m_grp, m_out;

  irq_group_steer #(.NUM_IN(NUM_IN), .CHAN_ID(CHAN), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mrd(input logic [7:0] a);
    int w;
    if (a[1:0] != 2'b00) return 32'h0;
    w = int'(a >> 2);
    if (w == 0) return m_ctrl;
    if (w >= 1 && w <= NW) return m_mask[32*(NW-w) +: 32];
    if (w >= NW+1 && w <= 2*NW) return m_force[32*(2*NW-w) +: 32];
    if (w >= 2*NW+1 && w <= 3*NW) return m_stat[32*(3*NW-w) +: 32];
    if (w == 3*NW+1) return m_mdis;
    if (w == 3*NW+2) return {{(32-NOUT){1'b0}}, m_grp};
    return 32'h0;
  endfunction

  task automatic tick();
    logic [NUM_IN-1:0] p;
    int w;
    @(posedge clk);
    if (!rst_n) begin
      m_mask = '0; m_force = '0; m_stat = '0; m_ctrl = '0; m_mdis = '0; m_grp = '0;
    end else begin
      p = (irq_in | m_force) & m_mask;
      m_stat = p;
      for (int j = 0; j < NOUT; j++) begin
        m_grp[j] = 1'b0;
        for (int b = 64*j; b < 64*j+64 && b < NUM_IN; b++) if (p[b]) m_grp[j] = 1'b1;
      end
      if (wr_en && addr[1:0] == 2'b00) begin
        w = int'(addr >> 2);
        if (w == 0) m_ctrl = wdata;
        if (w >= 1 && w <= NW) m_mask[32*(NW-w) +: 32] = wdata;
        if (w >= NW+1 && w <= 2*NW) m_force[32*(2*NW-w) +: 32] = wdata;
        if (w == 3*NW+1) m_mdis = wdata;
      end
    end
    m_out = (m_ctrl[CHAN] && m_mdis == 0) ? m_grp : '0;
    @(negedge clk);
    chk("R6 per-cycle irq_out", 32'(irq_out), 32'(m_out));
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    addr = a; wr_en = 1'b0;
    #1;
    chk(tag, rdata, mrd(a));
  endtask

  initial begin
    #(8*200000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    m_mask = '0; m_force = '0; m_stat = '0; m_ctrl = '0; m_mdis = '0; m_grp = '0; m_out = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    for (int a = 0; a <= 56; a += 4) begin
      addr = 8'(a); #1; chk("R1 reset readback", rdata, 32'h0);
    end
    chk("R1 outputs low", 32'(irq_out), 32'h0);

    // R8 unmapped and misaligned
    wr(8'd60, 32'hffff_ffff);
    rd("R8 unmapped read", 8'd60);
    chk("R8 unmapped read zero", rdata, 32'h0);
    wr(8'd5, 32'hffff_ffff);
    rd("R8 misaligned write ignored", 8'd4);
    chk("R8 mask untouched", rdata, 32'h0);
    addr = 8'd5; #1; chk("R8 misaligned read zero", rdata, 32'h0);

    // R3 input 0 sits in the highest-addressed enable word
    wr(8'd16, 32'h1);
    rd("R3 enable readback", 8'd16);
    irq_in[0] = 1'b1;
    tick();
    chk("R2 channel off keeps output low", 32'(irq_out), 32'h0);
    rd("R5 status of input 0", 8'd48);
    chk("R5 status word bit0", rdata, 32'h1);

    // R2 wrong channel bit, then the right one
    wr(8'd0, 32'h2);
    tick();
    chk("R2 other channel bit", 32'(irq_out), 32'h0);
    wr(8'd0, 32'h1 << CHAN);
    chk("R2 channel enabled", 32'(irq_out), 32'h1);
    rd("R2 ctrl readback", 8'd0);

    // R3 reversed order: word 0 bit 4 is input 100
    wr(8'd4, 32'h10);
    irq_in[100] = 1'b1;
    irq_in[99] = 1'b1;
    tick();
    chk("R3 top group output", 32'(irq_out), 32'h3);
    rd("R5 status word 0", 8'd36);
    chk("R5 masked input invisible", rdata, 32'h10);

    // R9 level drop
    irq_in[0] = 1'b0;
    tick();
    chk("R9 group 0 falls", 32'(irq_out), 32'h2);

    // R4 force input 37 (word 2 bit 5)
    wr(8'd28, 32'h20);
    tick();
    chk("R4 force without enable", 32'(irq_out), 32'h2);
    rd("R4 force readback", 8'd28);
    wr(8'd12, 32'h20);
    tick();
    chk("R4 forced input pending", 32'(irq_out), 32'h3);

    // R5 writes to status ignored
    wr(8'd36, 32'h0);
    tick();
    rd("R5 status write ignored", 8'd36);
    chk("R5 status still set", rdata, 32'h10);

    // R7 master disable
    wr(8'd52, 32'h1);
    chk("R7 outputs gated", 32'(irq_out), 32'h0);
    rd("R7 master status visible", 8'd56);
    chk("R7 master status value", rdata, 32'h3);
    rd("R7 mdis readback", 8'd52);
    wr(8'd52, 32'h0);
    chk("R7 outputs return", 32'(irq_out), 32'h3);

    // R9 all quiet
    irq_in = '0;
    wr(8'd28, 32'h0);
    tick();
    chk("R9 all outputs fall", 32'(irq_out), 32'h0);

    // R6 pseudo-random levels with all inputs enabled
    for (int i = 0; i < NW; i++) wr(8'(4 + 4*i), 32'hffff_ffff);
    lf = 32'h1;
    for (int n = 0; n < 60; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      irq_in = '0;
      if (lf[3]) irq_in[lf[10:4] % NUM_IN] = 1'b1;
      if (lf[12]) irq_in[lf[19:13] % NUM_IN] = 1'b1;
      tick();
      rd("R5 status random", 8'(36 + 4*(n % NW)));
      rd("R7 master status random", 8'd56);
    end

    // R1 reset again mid-run
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    irq_in = '0;
    tick();
    rd("R1 ctrl after reset", 8'd0);
    rd("R1 mask after reset", 8'd4);
    chk("R1 outputs low after reset", 32'(irq_out), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule